// File: doc/BRIEF.md
# CAN Controller Interrupt Register Bank

This block holds the interrupt flags of a CAN controller and presents them, together with a live status word and a bus-error capture word, on a small APB-style slave port. The protocol engine beside it reports one-cycle event pulses: transmission finished, frame received, bus error, arbitration lost and receive overrun. It also drives two level signals, the error status and the bus-off state. Any change of either level raises an error-warning event. Each source has its own enable bit, and a source whose enable is clear never latches a flag. The interrupt line is the OR of the latched flags.

Software acknowledges interrupts by reading the flag register. The read returns the flags and clears them at the end of its access phase. An event that lands in that same clock is not swallowed: it is set again after the clear. A bus error also records its error type and the frame field where it struck. This record is held until software reads the capture word, and later errors leave it untouched until then. Every access completes in its access phase with no wait states.

Top module: `can_irq_regs`

## Requirements
- R1: After reset all flags, all enable bits and the capture valid bit are 0, and `irq_o` is low.
- R2: The enable register at byte offset 0x4 is read/write in bits [5:0]. Flag bit i can only be set while enable bit i is 1.
- R3: A read of offset 0x0 returns the flags in bits [5:0]: 0 transmit done, 1 receive, 2 error warning, 3 bus error, 4 arbitration lost, 5 overrun. The flags clear at the clock edge that ends the read's access phase.
- R4: An enabled event in the same clock as the clearing read is not in that read's data but is set after it.
- R5: `irq_o` is high exactly when at least one flag is set.
- R6: A read of offset 0x8 returns the live inputs: bit 0 transmit buffer free, bit 1 error status, bit 2 bus-off.
- R7: When `err_status_i` or `bus_off_i` changes value, the error-warning flag (bit 2) is set at the next clock edge, if enabled.
- R8: A bus error loads its type into bits [6:5] and its field into bits [4:0] of the capture word at offset 0xC, and sets the valid bit 8. This happens whether or not the bus-error interrupt is enabled. While valid is set, later errors do not overwrite the word. A read of 0xC clears valid and keeps the fields.
- R9: A write to offset 0x0 leaves the flags unchanged. Read data is valid during the access phase itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 write, 0 read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid in the read access phase |
| evt_tx_done_i | input | 1 | Transmission finished pulse |
| evt_rx_i | input | 1 | Frame received pulse |
| evt_bus_err_i | input | 1 | Bus error pulse |
| evt_arb_lost_i | input | 1 | Arbitration lost pulse |
| evt_overrun_i | input | 1 | Receive overrun pulse |
| err_type_i | input | TYPE_W | Bus error type, valid with the bus error pulse |
| err_field_i | input | FIELD_W | Frame field of the bus error |
| txbuf_free_i | input | 1 | Transmit buffer free, live |
| err_status_i | input | 1 | Error status level |
| bus_off_i | input | 1 | Bus-off level |
| irq_o | output | 1 | Interrupt request |

## Verification
A clearing read of the flag register and a new event pulse can fall in the same clock. This is the case that decides whether an interrupt is lost. The bench drives transmit-done and receive pulses during the access phase of a flag read. It expects that read to return only the older flags. It then expects a second read to return the new event bit and a third read to return zero. The capture word has the same kind of collision between a held record and a later bus error. The bench checks that the later error leaves the word unchanged and that the first error after the read is recorded.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int NUM_SRC = 6;
  localparam int SRC_TX   = 0;
  localparam int SRC_RX   = 1;
  localparam int SRC_WARN = 2;
  localparam int SRC_BERR = 3;
  localparam int SRC_ARB  = 4;
  localparam int SRC_OVR  = 5;
  localparam int STAT_W   = 3;
  localparam int CAP_VALID_BIT = 8;

  typedef enum logic [1:0] {
    REG_INT  = 2'd0,
    REG_EN   = 2'd1,
    REG_STAT = 2'd2,
    REG_CAP  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/can_irq_decode.sv
module can_irq_decode
  import can_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output reg_sel_e          sel,
  output logic              rd_acc,
  output logic              rd_int,
  output logic              rd_cap,
  output logic              wr_en
);
  logic acc;

  always_comb begin
    sel    = reg_sel_e'(paddr[3:2]);
    acc    = psel & penable;
    rd_acc = acc & ~pwrite;
    rd_int = rd_acc & (sel == REG_INT);
    rd_cap = rd_acc & (sel == REG_CAP);
    wr_en  = acc & pwrite & (sel == REG_EN);
  end
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  input  logic         clr,
  output logic [N-1:0] set,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_comb begin
      set[i]     = evt[i] & en[i];
      flags_d[i] = set[i] | (flags_q[i] & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flags_d[i];
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/can_irq_errcap.sv
module can_irq_errcap #(
  parameter int TYPE_W  = 2,
  parameter int FIELD_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_err,
  input  logic [TYPE_W-1:0]  etype,
  input  logic [FIELD_W-1:0] efield,
  input  logic               rd_cap,
  output logic               cap_valid,
  output logic [TYPE_W-1:0]  cap_type,
  output logic [FIELD_W-1:0] cap_field
);
  logic               valid_q, valid_d;
  logic [TYPE_W-1:0]  type_q, type_d;
  logic [FIELD_W-1:0] field_q, field_d;
  logic               load;

  always_comb begin
    load    = bus_err & (~valid_q | rd_cap);
    type_d  = type_q;
    field_d = field_q;
    valid_d = valid_q;
    if (load) begin
      type_d  = etype;
      field_d = efield;
      valid_d = 1'b1;
    end else if (rd_cap) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      type_q  <= '0;
      field_q <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) begin
        type_q  <= type_d;
        field_q <= field_d;
      end
    end
  end

  assign cap_valid = valid_q;
  assign cap_type  = type_q;
  assign cap_field = field_q;
endmodule

// File: rtl/can_irq_regs.sv
module can_irq_regs
  import can_irq_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int TYPE_W  = 2,
  parameter int FIELD_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [DATA_W-1:0]  pwdata,
  output logic [DATA_W-1:0]  prdata,
  input  logic               evt_tx_done_i,
  input  logic               evt_rx_i,
  input  logic               evt_bus_err_i,
  input  logic               evt_arb_lost_i,
  input  logic               evt_overrun_i,
  input  logic [TYPE_W-1:0]  err_type_i,
  input  logic [FIELD_W-1:0] err_field_i,
  input  logic               txbuf_free_i,
  input  logic               err_status_i,
  input  logic               bus_off_i,
  output logic               irq_o
);
  localparam int CAP_W = FIELD_W + TYPE_W;

  logic               rst_meta_n, rst_sync_n;
  reg_sel_e           sel;
  logic               rd_acc, rd_int, rd_cap, wr_en;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic [NUM_SRC-1:0] evt, set, flags;
  logic               err_prev_q, off_prev_q;
  logic               warn_evt;
  logic               cap_valid;
  logic [TYPE_W-1:0]  cap_type;
  logic [FIELD_W-1:0] cap_field;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  can_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .sel(sel), .rd_acc(rd_acc), .rd_int(rd_int), .rd_cap(rd_cap), .wr_en(wr_en)
  );

  // enable register
  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = pwdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) en_q <= '0;
    else if (wr_en)  en_q <= en_d;
  end

  // level change detect for the warning source
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_prev_q <= 1'b0;
      off_prev_q <= 1'b0;
    end else begin
      err_prev_q <= err_status_i;
      off_prev_q <= bus_off_i;
    end
  end

  always_comb begin
    warn_evt       = (err_prev_q ^ err_status_i) | (off_prev_q ^ bus_off_i);
    evt            = '0;
    evt[SRC_TX]    = evt_tx_done_i;
    evt[SRC_RX]    = evt_rx_i;
    evt[SRC_WARN]  = warn_evt;
    evt[SRC_BERR]  = evt_bus_err_i;
    evt[SRC_ARB]   = evt_arb_lost_i;
    evt[SRC_OVR]   = evt_overrun_i;
  end

  can_irq_flags #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .evt(evt), .en(en_q),
    .clr(rd_int), .set(set), .flags(flags)
  );

  can_irq_errcap #(.TYPE_W(TYPE_W), .FIELD_W(FIELD_W)) u_cap (
    .clk(clk), .rst_n(rst_sync_n), .bus_err(evt_bus_err_i),
    .etype(err_type_i), .efield(err_field_i), .rd_cap(rd_cap),
    .cap_valid(cap_valid), .cap_type(cap_type), .cap_field(cap_field)
  );

  // read mux, valid in the access phase
  always_comb begin
    prdata = '0;
    if (rd_acc) begin
      case (sel)
        REG_INT:  prdata[NUM_SRC-1:0] = flags;
        REG_EN:   prdata[NUM_SRC-1:0] = en_q;
        REG_STAT: prdata[STAT_W-1:0]  = {bus_off_i, err_status_i, txbuf_free_i};
        REG_CAP: begin
          prdata[CAP_W-1:0]     = {cap_type, cap_field};
          prdata[CAP_VALID_BIT] = cap_valid;
        end
        default: prdata = '0;
      endcase
    end
  end

  assign irq_o = |flags;
endmodule

// File: rtl/can_irq_regs_chk.sv
module can_irq_regs_chk #(
  parameter int N = 6,
  parameter int TYPE_W = 2,
  parameter int FIELD_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_int,
  input logic               rd_cap,
  input logic               wr_int,
  input logic               bus_err,
  input logic [N-1:0]       en,
  input logic [N-1:0]       set,
  input logic [N-1:0]       flags,
  input logic               cap_valid,
  input logic [TYPE_W-1:0]  cap_type,
  input logic [FIELD_W-1:0] cap_field,
  input logic               irq
);
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_int && set == '0) |=> flags == '0);

  assert_no_lost_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_int && set != '0) |=> ((flags & $past(set)) == $past(set)));

  assert_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(en) & ~$past(flags)) == '0));

  assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != '0) |-> irq);

  assert_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !rd_cap) |=> ($stable(cap_type) && $stable(cap_field) && cap_valid));

  assert_cap_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !cap_valid) |=> cap_valid);

  assert_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_int && set == '0) |=> $stable(flags));
endmodule

bind can_irq_regs can_irq_regs_chk #(
  .N(can_irq_pkg::NUM_SRC), .TYPE_W(TYPE_W), .FIELD_W(FIELD_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rd_int(rd_int), .rd_cap(rd_cap),
  .wr_int(psel & penable & pwrite & (paddr[3:2] == 2'd0)),
  .bus_err(evt_bus_err_i), .en(en_q), .set(set), .flags(flags),
  .cap_valid(cap_valid), .cap_type(cap_type), .cap_field(cap_field), .irq(irq_o)
);

// File: tb/tb_can_irq_regs.sv
module tb_can_irq_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              psel = 0, penable = 0, pwrite = 0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [DATA_W-1:0] pwdata = '0;
  logic [DATA_W-1:0] prdata;
  logic              ev_tx = 0, ev_rx = 0, ev_berr = 0, ev_arb = 0, ev_ovr = 0;
  logic [1:0]        etype = '0;
  logic [4:0]        efield = '0;
  logic              txfree = 0, errst = 0, busoff = 0;
  logic              irq;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [DATA_W-1:0] exp;
    string             tag;
  } exp_t;
  exp_t sb[$];

  can_irq_regs dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .evt_tx_done_i(ev_tx), .evt_rx_i(ev_rx), .evt_bus_err_i(ev_berr),
    .evt_arb_lost_i(ev_arb), .evt_overrun_i(ev_ovr),
    .err_type_i(etype), .err_field_i(efield),
    .txbuf_free_i(txfree), .err_status_i(errst), .bus_off_i(busoff),
    .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares read data in the access phase
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected read, actual %h expected none", "R9", prdata);
      end else begin
        e = sb.pop_front();
        if (prdata !== e.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", e.tag, prdata, e.exp);
        end
      end
    end
  end

  task automatic set_evt(input logic [5:0] m);
    ev_tx = m[0]; ev_rx = m[1]; ev_berr = m[3]; ev_arb = m[4]; ev_ovr = m[5];
  endtask

  // read with optional event pulse in the access phase
  task automatic rd(input logic [3:0] a, input logic [DATA_W-1:0] exp,
                    input string tag, input logic [5:0] ev = 6'h0);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge clk); #1;
    penable = 1; set_evt(ev);
    @(posedge clk); #1;
    psel = 0; penable = 0; set_evt(6'h0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [DATA_W-1:0] d);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic pulse(input logic [5:0] m);
    @(posedge clk); #1;
    set_evt(m);
    @(posedge clk); #1;
    set_evt(6'h0);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(4'h0, 32'h0, "R1 flags");
    rd(4'h4, 32'h0, "R1 enable");
    rd(4'hC, 32'h0, "R1 capture");
    // R2 enable register
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, 32'h3F, "R2 enable readback");
    // R3 set and clear
    pulse(6'h01);
    chk_irq(1'b1, "R5");
    rd(4'h0, 32'h01, "R3 tx flag");
    rd(4'h0, 32'h00, "R3 cleared");
    chk_irq(1'b0, "R5 after clear");
    // R2 disabled source
    wr(4'h4, 32'h3E);
    pulse(6'h01);
    chk_irq(1'b0, "R2 disabled");
    rd(4'h0, 32'h00, "R2 disabled flag");
    wr(4'h4, 32'h3F);
    // R3 several sources
    pulse(6'h32);
    rd(4'h0, 32'h32, "R3 rx arb ovr");
    // R4 event in the clearing cycle
    pulse(6'h10);
    rd(4'h0, 32'h10, "R4 old flags only", 6'h01);
    rd(4'h0, 32'h01, "R4 tx survives", 6'h02);
    rd(4'h0, 32'h02, "R4 rx survives");
    rd(4'h0, 32'h00, "R4 cleared");
    // R9 write to flag register ignored
    pulse(6'h20);
    wr(4'h0, 32'h0);
    chk_irq(1'b1, "R9 write ignored");
    rd(4'h0, 32'h20, "R9 flags kept");
    // R6 live status
    txfree = 1;
    rd(4'h8, 32'h1, "R6 status");
    // R7 warning on level change
    errst = 1;
    repeat (2) @(posedge clk); #1;
    rd(4'h8, 32'h3, "R6 status err");
    rd(4'h0, 32'h04, "R7 warn err change");
    busoff = 1;
    repeat (2) @(posedge clk); #1;
    rd(4'h0, 32'h04, "R7 warn busoff change");
    rd(4'h0, 32'h00, "R7 no change no warn");
    // R8 capture
    etype = 2'd2; efield = 5'h11;
    pulse(6'h08);
    etype = 2'd1; efield = 5'h03;
    pulse(6'h08);
    rd(4'h0, 32'h08, "R8 bus error flag");
    rd(4'hC, 32'h151, "R8 first error held");
    rd(4'hC, 32'h051, "R8 valid cleared");
    wr(4'h4, 32'h00);
    etype = 2'd3; efield = 5'h07;
    pulse(6'h08);
    rd(4'hC, 32'h167, "R8 captured while disabled");
    rd(4'h0, 32'h00, "R2 bus error disabled");
    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule